// File: doc/BRIEF.md
# Masked Word Blend Unit

This execution unit forms a vector result by picking each 16-bit word from one of two source operands. The picking is controlled by an 8-bit immediate mask. The datapath is 256 bits wide and is split into two 128-bit lanes of eight words each.

A two-bit variant code chooses how the upper lane is handled:

- **Merge variant.** The first source is the prior destination value, and the upper lane keeps its prior contents.
- **Zeroing variant.** The upper lane is cleared.
- **Full-width variant.** The same eight mask bits also blend the upper lane.

A capability input enables the full-width variant. Using that variant while the capability is off, or using the reserved code, raises an invalid-opcode fault. A faulting operation leaves the result untouched.

The unit issues at most one operation per cycle. Each operation is started with `in_valid`. The result register and its flags appear one clock later. The unit produces no arithmetic status flags.

Top module: `word_blend_unit`

## Requirements
- R1: In the lower lane, mask bit i (word i = bits 16i+15..16i) selects the `src_b` word when 1 and the first-source word when 0.
- R2: With variant code 2'b00 (merge) the first source is `dst_prior`; `src_a` has no effect on the result.
- R3: With variant 2'b00, result bits 255:128 equal `dst_prior` bits 255:128.
- R4: With variant 2'b01 (zeroing) the first source is `src_a`, and result bits 255:128 are zero.
- R5: With variant 2'b10 (full-width) and `wide_en` = 1, mask bit i also selects upper word i+8 (bits 16i+143..16i+128), taking `src_b` when 1 and `src_a` when 0.
- R6: `res_valid` rises exactly one clock after an `in_valid` cycle, and a non-faulting operation's result appears on that same cycle.
- R7: Variant 2'b11, or variant 2'b10 with `wide_en` = 0, sets `fault` in the same cycle as `res_valid`; a legal operation leaves `fault` low.
- R8: While `fault` is high, `result` keeps its previous value.
- R9: Synchronous active-high `rst` clears `result`, `res_valid` and `fault`.
- R10: A cycle without `in_valid` is followed by `res_valid` = 0, `fault` = 0 and an unchanged `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| variant | input | 2 | 00 merge, 01 zeroing, 10 full-width, 11 reserved |
| wide_en | input | 1 | Full-width capability enable |
| imm | input | 8 | Word select mask |
| src_a | input | 256 | First source (unused by the merge variant) |
| src_b | input | 256 | Second source |
| dst_prior | input | 256 | Prior destination value |
| result | output | 256 | Registered result |
| res_valid | output | 1 | Result valid, one clock after `in_valid` |
| fault | output | 1 | Invalid-opcode fault, aligned with `res_valid` |

## Verification
Every output is due on the clock edge after the `in_valid` cycle: `result`, `res_valid` and `fault` all come from the same single register stage. The bench drives each operation on a falling edge and holds `in_valid` for exactly one cycle. It then samples on the next falling edge, which falls after the one register update.

Idle cycles are sampled one falling edge after `in_valid` drops, so the hold behaviour is checked in the cycle it applies to. Fault cases are checked against the result captured one cycle earlier.

// File: rtl/word_blend_pkg.sv
package word_blend_pkg;
  typedef enum logic [1:0] {
    VAR_MERGE  = 2'b00,
    VAR_ZERO   = 2'b01,
    VAR_FULL   = 2'b10,
    VAR_RSVD   = 2'b11
  } blend_var_e;

  // Illegal when reserved, or full width without the capability.
  function automatic logic op_faults(input blend_var_e v, input logic wide_en);
    return (v == VAR_RSVD) || ((v == VAR_FULL) && !wide_en);
  endfunction
endpackage

// File: rtl/word_blend_lane.sv
module word_blend_lane #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  localparam int LANE_W = WORD_W * WORDS
) (
  input  logic [WORDS-1:0]  sel_b,
  input  logic [LANE_W-1:0] first,
  input  logic [LANE_W-1:0] second,
  output logic [LANE_W-1:0] lane_out
);
  function automatic logic [WORD_W-1:0] pick(input logic s,
                                             input logic [WORD_W-1:0] x,
                                             input logic [WORD_W-1:0] y);
    return s ? y : x;
  endfunction

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign lane_out[w*WORD_W +: WORD_W] =
      pick(sel_b[w], first[w*WORD_W +: WORD_W], second[w*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/word_blend_ctl.sv
module word_blend_ctl
  import word_blend_pkg::*;
(
  input  logic       in_valid,
  input  logic [1:0] variant,
  input  logic       wide_en,
  output logic       fault_now,
  output logic       accept,
  output logic       keep_upper,
  output logic       zero_upper
);
  blend_var_e v;
  always_comb begin
    v          = blend_var_e'(variant);
    fault_now  = in_valid && op_faults(v, wide_en);
    accept     = in_valid && !op_faults(v, wide_en);
    keep_upper = (v == VAR_MERGE);
    zero_upper = (v == VAR_ZERO);
  end
endmodule

// File: rtl/word_blend_unit.sv
module word_blend_unit #(
  parameter int WORD_W         = 16,
  parameter int WORDS_PER_LANE = 8,
  parameter int LANES          = 2,
  localparam int LANE_W = WORD_W * WORDS_PER_LANE,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [1:0]                variant,
  input  logic                      wide_en,
  input  logic [WORDS_PER_LANE-1:0] imm,
  input  logic [DATA_W-1:0]         src_a,
  input  logic [DATA_W-1:0]         src_b,
  input  logic [DATA_W-1:0]         dst_prior,
  output logic [DATA_W-1:0]         result,
  output logic                      res_valid,
  output logic                      fault
);
  logic fault_now, accept, keep_upper, zero_upper;
  logic [DATA_W-1:0] next_res;
  logic [DATA_W-1:0] res_q;
  logic vld_q, flt_q;

  word_blend_ctl u_ctl (
    .in_valid  (in_valid),
    .variant   (variant),
    .wide_en   (wide_en),
    .fault_now (fault_now),
    .accept    (accept),
    .keep_upper(keep_upper),
    .zero_upper(zero_upper)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] first_src;
    logic [LANE_W-1:0] blended;

    if (l == 0) begin : g_low
      // Merge variant blends into the destination itself.
      assign first_src = keep_upper ? dst_prior[l*LANE_W +: LANE_W]
                                    : src_a[l*LANE_W +: LANE_W];
      assign next_res[l*LANE_W +: LANE_W] = blended;
    end else begin : g_high
      assign first_src = src_a[l*LANE_W +: LANE_W];
      assign next_res[l*LANE_W +: LANE_W] =
        keep_upper ? dst_prior[l*LANE_W +: LANE_W] :
        zero_upper ? '0 : blended;
    end

    word_blend_lane #(.WORD_W(WORD_W), .WORDS(WORDS_PER_LANE)) u_lane (
      .sel_b   (imm),
      .first   (first_src),
      .second  (src_b[l*LANE_W +: LANE_W]),
      .lane_out(blended)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      flt_q <= fault_now;
      if (accept) res_q <= next_res;
    end
  end

  assign result    = res_q;
  assign res_valid = vld_q;
  assign fault     = flt_q;
endmodule

// File: rtl/word_blend_unit_chk.sv
module word_blend_unit_chk #(
  parameter int LANE_W = 128,
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        variant,
  input logic              wide_en,
  input logic              accept,
  input logic [DATA_W-1:0] dst_prior,
  input logic [DATA_W-1:0] result,
  input logic              res_valid,
  input logic              fault
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R6
  AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    accept |=> (res_valid && !fault)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !fault && $stable(result))); // R10
  AST_BAD_CODE_FAULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (variant == 2'b11 || (variant == 2'b10 && !wide_en))) |=> fault); // R7
  AST_FAULT_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    fault |-> res_valid); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    fault |-> $stable(result)); // R8
  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && variant == 2'b01) |=> (result[DATA_W-1:LANE_W] == '0)); // R4
  AST_MERGE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && variant == 2'b00) |=>
      (result[DATA_W-1:LANE_W] == $past(dst_prior[DATA_W-1:LANE_W]))); // R3
endmodule

bind word_blend_unit word_blend_unit_chk #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .variant  (variant),
  .wide_en  (wide_en),
  .accept   (accept),
  .dst_prior(dst_prior),
  .result   (result),
  .res_valid(res_valid),
  .fault    (fault)
);

// File: tb/word_blend_unit_bench.sv
module word_blend_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   variant;
  logic         wide_en;
  logic [7:0]   imm;
  logic [255:0] src_a, src_b, dst_prior;
  logic [255:0] result;
  logic         res_valid, fault;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  word_blend_unit u_word_blend_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .variant(variant),
    .wide_en(wide_en), .imm(imm), .src_a(src_a), .src_b(src_b),
    .dst_prior(dst_prior), .result(result), .res_valid(res_valid),
    .fault(fault)
  );

  // Word-by-word restatement of the requirements.
  function automatic logic [255:0] model(input logic [1:0] v, input logic [7:0] m,
                                         input logic [255:0] a, input logic [255:0] b,
                                         input logic [255:0] d);
    logic [255:0] r;
    for (int w = 0; w < 16; w++) begin
      int i;
      logic [15:0] aw, bw, dw;
      i  = w % 8;
      aw = a[16*w +: 16];
      bw = b[16*w +: 16];
      dw = d[16*w +: 16];
      if (w < 8)          r[16*w +: 16] = m[i] ? bw : ((v == 2'b00) ? dw : aw); // R1 R2
      else if (v == 2'b00) r[16*w +: 16] = dw;                                  // R3
      else if (v == 2'b01) r[16*w +: 16] = 16'h0;                               // R4
      else                 r[16*w +: 16] = m[i] ? bw : aw;                      // R5
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] v, input logic we, input logic [7:0] m,
                       input logic [255:0] a, input logic [255:0] b,
                       input logic [255:0] d);
    @(negedge clk);
    in_valid = 1'b1; variant = v; wide_en = we; imm = m;
    src_a = a; src_b = b; dst_prior = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fill(input int seed, output logic [255:0] a, output logic [255:0] b,
                      output logic [255:0] d);
    for (int w = 0; w < 16; w++) begin
      a[16*w +: 16] = 16'hA000 + 16'(seed * 16 + w);
      b[16*w +: 16] = 16'hB000 + 16'(seed * 32 + w);
      d[16*w +: 16] = 16'hD000 + 16'(seed * 8 + w * 3);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, d, exp, prev;
    rst = 1'b1; in_valid = 1'b0; variant = 2'b00; wide_en = 1'b1; imm = 8'h00;
    src_a = '1; src_b = '1; dst_prior = '1;
    repeat (3) @(negedge clk);
    check(result == '0 && !res_valid && !fault, "R9 reset", {254'(result), res_valid, fault}, '0);
    rst = 1'b0;

    // Sweep every mask for each legal variant.
    for (int v = 0; v < 3; v++) begin
      for (int m = 0; m < 256; m++) begin
        fill(m + v * 300, a, b, d);
        issue(2'(v), 1'b1, 8'(m), a, b, d);
        exp = model(2'(v), 8'(m), a, b, d);
        check(res_valid && !fault, "R6 R7 valid", {254'(0), res_valid, fault}, 256'b10);
        check(result == exp, (v == 0) ? "R1 R3 merge" : (v == 1) ? "R1 R4 zero" : "R5 full",
              result, exp);
      end
    end

    // R2: inverting src_a changes nothing in the merge variant.
    fill(7, a, b, d);
    issue(2'b00, 1'b1, 8'h5A, ~a, b, d);
    exp = model(2'b00, 8'h5A, a, b, d);
    check(result == exp, "R2 src_a ignored", result, exp);

    // R10: an idle cycle holds the result and drops valid.
    prev = result;
    @(negedge clk);
    check(result == prev && !res_valid && !fault, "R10 idle", result, prev);

    // R7 R8: full width with the capability off.
    issue(2'b10, 1'b0, 8'hFF, ~a, ~b, ~d);
    check(res_valid && fault, "R7 no capability", {254'(0), res_valid, fault}, 256'b11);
    check(result == prev, "R8 hold on fault", result, prev);

    // R7 R8: reserved code, even with the capability on.
    issue(2'b11, 1'b1, 8'h0F, ~a, ~b, ~d);
    check(res_valid && fault, "R7 reserved", {254'(0), res_valid, fault}, 256'b11);
    check(result == prev, "R8 hold reserved", result, prev);

    // R7: legal operation right after a fault clears the flag.
    fill(9, a, b, d);
    issue(2'b10, 1'b1, 8'hC3, a, b, d);
    exp = model(2'b10, 8'hC3, a, b, d);
    check(!fault && result == exp, "R7 R5 recovery", result, exp);

    // R9: reset mid-stream.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(result == '0 && !res_valid && !fault, "R9 reset again", result, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule